// File: doc/BRIEF.md
# Zero-Overhead Nested Loop Controller

This block sits beside an instruction fetch unit and picks the next fetch address so that counted loops repeat without any branch instruction and without a misprediction bubble. It keeps two loop levels. Level 0 is the inner loop and level 1 is the outer loop. Each level has its own start address and remaining-iteration count. A loop-setup command fills one level with both values at once.

Every fetched packet arrives with two end-of-loop marker bits, one for each level. When the packet that closes a loop is fetched, the controller compares that level's count against one. It then either steers fetch back to the loop start in the same cycle or lets fetch continue to the sequential address. The count is updated on the following clock edge.

A small register port lets software save and restore all four loop registers.

Top module: `zloop_ctrl`

## Requirements
- R1: After reset both counts and both start addresses read as zero, `redirect` is low, and `next_addr` equals `seq_addr`.
- R2: A setup command (`setup_valid` high) loads `setup_start` and `setup_count` into the level chosen by `setup_lvl` (0 = inner, 1 = outer) at the next clock edge.
- R3: A valid packet marked as the end of a level whose count is above one raises `redirect` and drives that level's start address on `next_addr` in the same cycle. The count drops by one at the next edge.
- R4: A valid packet marked as the end of a level whose count is one or zero leaves `redirect` low and passes `seq_addr` through. That count becomes zero at the next edge.
- R5: A count loaded as zero runs the loop body exactly once: the first end marker falls through.
- R6: If one packet carries both marker bits, the inner level is resolved first. When the inner level loops back, the outer count is left unchanged. When the inner level expires, the outer level is resolved in the same cycle.
- R7: Marker bits have no effect while `fetch_valid` is low.
- R8: The register port reads and writes each loop register. `reg_addr` bit 1 selects the level, and bit 0 selects the start address (0) or the count (1, placed in the low bits of the data word and zero-extended on read). A read is combinational.
- R9: Within one level in one cycle, a setup command wins over a register-port write, and a register-port write wins over the loop-end count update.
- R10: `redirect` is never raised without a valid packet that carries a marker bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | A packet is being fetched this cycle |
| seq_addr | input | AW | Sequential next fetch address |
| end_l0 | input | 1 | Packet closes the inner loop |
| end_l1 | input | 1 | Packet closes the outer loop |
| setup_valid | input | 1 | Loop-setup command |
| setup_lvl | input | 1 | Level targeted by setup |
| setup_start | input | AW | Loop start address for setup |
| setup_count | input | CW | Iteration count for setup |
| reg_we | input | 1 | Register-port write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | AW | Register-port write data |
| reg_rdata | output | AW | Register-port read data |
| redirect | output | 1 | Fetch is steered to a loop start |
| next_addr | output | AW | Next fetch address |

## Verification
The inner and outer loop ends can fall on the same packet. Two situations are provoked by fetching a packet with both marker bits set. In the first, the inner count is above one. The bench then requires a jump to the inner start, and a later outer expiry shows that the outer count was left untouched. In the second, the inner count is already spent. The bench then requires the outer level to loop back, or to fall through when it is also spent, all within that single cycle.

A second collision is also exercised. A register write lands on a count in the same cycle as that count's loop-back. The write must win, and this is judged by reading the count back.

// File: rtl/zl_pkg.sv
package zl_pkg;
    localparam int NLVL = 2;

    typedef enum logic [1:0] {
        RSEL_START0 = 2'd0,
        RSEL_COUNT0 = 2'd1,
        RSEL_START1 = 2'd2,
        RSEL_COUNT1 = 2'd3
    } rsel_e;
endpackage

// File: rtl/zl_eval.sv
// Per-level loop-end decision: purely combinational.
module zl_eval #(
    parameter int CW = 16
) (
    input  logic          valid,
    input  logic          marker,
    input  logic          enable,
    input  logic [CW-1:0] cnt,
    output logic          loop_back,
    output logic          expire
);
    logic hit;
    logic more;

    always_comb begin
        hit       = valid && marker && enable;
        more      = cnt > CW'(1);
        loop_back = hit && more;
        expire    = hit && !more;
    end
endmodule

// File: rtl/zl_regs.sv
// Loop context storage with setup, register port and loop-end updates.
module zl_regs
    import zl_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      setup_valid,
    input  logic                      setup_lvl,
    input  logic [AW-1:0]             setup_start,
    input  logic [CW-1:0]             setup_count,
    input  logic                      reg_we,
    input  logic [1:0]                reg_addr,
    input  logic [AW-1:0]             reg_wdata,
    input  logic [NLVL-1:0]           loop_back,
    input  logic [NLVL-1:0]           expire,
    output logic [NLVL-1:0][AW-1:0]   start_o,
    output logic [NLVL-1:0][CW-1:0]   cnt_o,
    output logic [AW-1:0]             reg_rdata
);
    typedef struct packed {
        logic [NLVL-1:0][AW-1:0] start;
        logic [NLVL-1:0][CW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    rsel_e  rsel;

    always_comb begin
        st_d = st_q;
        rsel = rsel_e'(reg_addr);
        for (int l = 0; l < NLVL; l++) begin
            logic setup_hit, wr_lvl, wr_start, wr_cnt;
            setup_hit = setup_valid && (int'(setup_lvl) == l);
            wr_lvl    = reg_we && (int'(reg_addr[1]) == l);
            wr_start  = wr_lvl && !reg_addr[0];
            wr_cnt    = wr_lvl && reg_addr[0];

            if (setup_hit)
                st_d.start[l] = setup_start;
            else if (wr_start)
                st_d.start[l] = reg_wdata;

            if (setup_hit)
                st_d.cnt[l] = setup_count;
            else if (wr_cnt)
                st_d.cnt[l] = reg_wdata[CW-1:0];
            else if (loop_back[l])
                st_d.cnt[l] = st_q.cnt[l] - CW'(1);
            else if (expire[l])
                st_d.cnt[l] = '0;
        end

        unique case (rsel)
            RSEL_START0: reg_rdata = st_q.start[0];
            RSEL_COUNT0: reg_rdata = AW'(st_q.cnt[0]);
            RSEL_START1: reg_rdata = st_q.start[1];
            default:     reg_rdata = AW'(st_q.cnt[1]);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign start_o = st_q.start;
    assign cnt_o   = st_q.cnt;
endmodule

// File: rtl/zloop_ctrl.sv
module zloop_ctrl
    import zl_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [AW-1:0] seq_addr,
    input  logic          end_l0,
    input  logic          end_l1,
    input  logic          setup_valid,
    input  logic          setup_lvl,
    input  logic [AW-1:0] setup_start,
    input  logic [CW-1:0] setup_count,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          redirect,
    output logic [AW-1:0] next_addr
);
    logic [NLVL-1:0][AW-1:0] start_q;
    logic [NLVL-1:0][CW-1:0] cnt_q;
    logic [NLVL-1:0]         loop_back;
    logic [NLVL-1:0]         expire;
    logic [NLVL-1:0]         marks;
    logic [NLVL-1:0]         lvl_en;

    assign marks  = {end_l1, end_l0};
    // The outer level is only considered once the inner one does not loop back.
    assign lvl_en = {~loop_back[0], 1'b1};

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        zl_eval #(.CW(CW)) u_eval (
            .valid     (fetch_valid),
            .marker    (marks[g]),
            .enable    (lvl_en[g]),
            .cnt       (cnt_q[g]),
            .loop_back (loop_back[g]),
            .expire    (expire[g])
        );
    end

    zl_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_valid (setup_valid),
        .setup_lvl   (setup_lvl),
        .setup_start (setup_start),
        .setup_count (setup_count),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .loop_back   (loop_back),
        .expire      (expire),
        .start_o     (start_q),
        .cnt_o       (cnt_q),
        .reg_rdata   (reg_rdata)
    );

    always_comb begin
        redirect = |loop_back;
        if (loop_back[0])
            next_addr = start_q[0];
        else if (loop_back[1])
            next_addr = start_q[1];
        else
            next_addr = seq_addr;
    end
endmodule

// File: rtl/zloop_ctrl_chk.sv
module zloop_ctrl_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fetch_valid,
    input logic [AW-1:0]       seq_addr,
    input logic                end_l0,
    input logic                end_l1,
    input logic                setup_valid,
    input logic                setup_lvl,
    input logic [CW-1:0]       setup_count,
    input logic                reg_we,
    input logic                redirect,
    input logic [AW-1:0]       next_addr,
    input logic [1:0][AW-1:0]  start_q,
    input logic [1:0][CW-1:0]  cnt_q
);
    logic quiet;
    assign quiet = !setup_valid && !reg_we;

    assert_redirect_needs_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> fetch_valid && (end_l0 || end_l1));

    assert_inner_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && end_l0 && cnt_q[0] > CW'(1)) |-> (redirect && next_addr == start_q[0]));

    assert_inner_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && end_l0 && cnt_q[0] > CW'(1) && quiet) |=> cnt_q[0] == CW'($past(cnt_q[0]) - CW'(1)));

    assert_inner_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && end_l0 && cnt_q[0] <= CW'(1) && quiet) |=> cnt_q[0] == '0);

    assert_fallthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !redirect) |-> next_addr == seq_addr);

    assert_outer_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && end_l0 && end_l1 && cnt_q[0] > CW'(1) && quiet) |=> $stable(cnt_q[1]));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && quiet) |=> $stable(cnt_q));

    assert_setup_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && !setup_lvl) |=> cnt_q[0] == $past(setup_count));
endmodule

bind zloop_ctrl zloop_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .seq_addr    (seq_addr),
    .end_l0      (end_l0),
    .end_l1      (end_l1),
    .setup_valid (setup_valid),
    .setup_lvl   (setup_lvl),
    .setup_count (setup_count),
    .reg_we      (reg_we),
    .redirect    (redirect),
    .next_addr   (next_addr),
    .start_q     (start_q),
    .cnt_q       (cnt_q)
);

// File: tb/zloop_ctrl_test.sv
module zloop_ctrl_test;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] seq_addr = '0;
    logic          end_l0 = 1'b0;
    logic          end_l1 = 1'b0;
    logic          setup_valid = 1'b0;
    logic          setup_lvl = 1'b0;
    logic [AW-1:0] setup_start = '0;
    logic [CW-1:0] setup_count = '0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          redirect;
    logic [AW-1:0] next_addr;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    zloop_ctrl #(.AW(AW), .CW(CW)) uut (.*);

    typedef struct packed {
        logic [3:0]  rq;
        logic        sv;
        logic        sl;
        logic [15:0] ss;
        logic [15:0] sc;
        logic        fv;
        logic        e0;
        logic        e1;
        logic [15:0] seq;
        logic        er;
        logic [15:0] en;
    } row_t;

    localparam int NROW = 13;
    // Fields: req, setup valid/level/start/count, fetch valid, end0, end1, seq, exp redirect, exp next
    localparam row_t ROWS [NROW] = '{
        '{4'd2, 1'b1, 1'b0, 16'h0100, 16'd3, 1'b0, 1'b0, 1'b0, 16'h0010, 1'b0, 16'h0010}, // R2 inner setup
        '{4'd2, 1'b1, 1'b1, 16'h0080, 16'd2, 1'b0, 1'b0, 1'b0, 16'h0014, 1'b0, 16'h0014}, // R2 outer setup
        '{4'd3, 1'b0, 1'b0, 16'h0000, 16'd0, 1'b1, 1'b1, 1'b0, 16'h0120, 1'b1, 16'h0100}, // R3 3 -> 2
        '{4'd3, 1'b0, 1'b0, 16'h0000, 16'd0, 1'b1, 1'b1, 1'b0, 16'h0120, 1'b1, 16'h0100}, // R3 2 -> 1
        '{4'd4, 1'b0, 1'b0, 16'h0000, 16'd0, 1'b1, 1'b1, 1'b0, 16'h0120, 1'b0, 16'h0120}, // R4 expire
        '{4'd10,1'b0, 1'b0, 16'h0000, 16'd0, 1'b1, 1'b0, 1'b0, 16'h0124, 1'b0, 16'h0124}, // R10 no mark
        '{4'd6, 1'b0, 1'b0, 16'h0000, 16'd0, 1'b1, 1'b1, 1'b1, 16'h0130, 1'b1, 16'h0080}, // R6 inner spent, outer 2 -> 1
        '{4'd2, 1'b1, 1'b0, 16'h0100, 16'd2, 1'b0, 1'b0, 1'b0, 16'h0134, 1'b0, 16'h0134}, // R2 reload inner
        '{4'd6, 1'b0, 1'b0, 16'h0000, 16'd0, 1'b1, 1'b1, 1'b1, 16'h0130, 1'b1, 16'h0100}, // R6 inner first, outer held
        '{4'd6, 1'b0, 1'b0, 16'h0000, 16'd0, 1'b1, 1'b1, 1'b1, 16'h0130, 1'b0, 16'h0130}, // R6 both expire
        '{4'd7, 1'b0, 1'b0, 16'h0000, 16'd0, 1'b0, 1'b1, 1'b1, 16'h0140, 1'b0, 16'h0140}, // R7 invalid fetch
        '{4'd2, 1'b1, 1'b0, 16'h0200, 16'd0, 1'b0, 1'b0, 1'b0, 16'h0144, 1'b0, 16'h0144}, // R2 zero count
        '{4'd5, 1'b0, 1'b0, 16'h0000, 16'd0, 1'b1, 1'b1, 1'b0, 16'h0210, 1'b0, 16'h0210}  // R5 runs once
    };

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        fetch_valid = 0; end_l0 = 0; end_l1 = 0;
        setup_valid = 0; reg_we = 0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [AW-1:0] exp);
        @(negedge clk);
        idle();
        reg_addr = a;
        #2;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        idle();
        reg_we = 1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        seq_addr = 32'h10;
        repeat (2) @(negedge clk);
        #2;
        // R1: reset state
        chk("R1 redirect", {31'd0, redirect}, 32'd0);
        chk("R1 next_addr", next_addr, 32'h10);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) rd("R1 readback", 2'(a), 32'd0);

        // Table walk
        for (int i = 0; i < NROW; i++) begin
            @(negedge clk);
            idle();
            setup_valid = ROWS[i].sv;
            setup_lvl   = ROWS[i].sl;
            setup_start = AW'(ROWS[i].ss);
            setup_count = ROWS[i].sc;
            fetch_valid = ROWS[i].fv;
            end_l0      = ROWS[i].e0;
            end_l1      = ROWS[i].e1;
            seq_addr    = AW'(ROWS[i].seq);
            #2;
            chk($sformatf("R%0d row%0d redirect", ROWS[i].rq, i), {31'd0, redirect}, {31'd0, ROWS[i].er});
            chk($sformatf("R%0d row%0d next_addr", ROWS[i].rq, i), next_addr, AW'(ROWS[i].en));
        end
        rd("R5 count after single pass", 2'd1, 32'd0);

        // R8: save/restore through the register port
        wr(2'd2, 32'h3000);
        wr(2'd3, 32'd5);
        rd("R8 start1", 2'd2, 32'h3000);
        rd("R8 count1", 2'd3, 32'd5);

        // R9: setup beats register write on the same level
        @(negedge clk);
        idle();
        setup_valid = 1; setup_lvl = 1; setup_start = 32'h400; setup_count = 16'd7;
        reg_we = 1; reg_addr = 2'd3; reg_wdata = 32'd9;
        rd("R9 setup wins count", 2'd3, 32'd7);
        rd("R9 setup wins start", 2'd2, 32'h400);

        // R9: register write beats loop-back decrement (redirect still taken)
        @(negedge clk);
        idle();
        fetch_valid = 1; end_l1 = 1; seq_addr = 32'h500;
        reg_we = 1; reg_addr = 2'd3; reg_wdata = 32'd4;
        #2;
        chk("R9 redirect during write", next_addr, 32'h400);
        rd("R9 write wins count", 2'd3, 32'd4);

        // R7: marker with no valid fetch leaves count alone
        @(negedge clk);
        idle();
        end_l1 = 1;
        rd("R7 count held", 2'd3, 32'd4);

        // R3: decrement visible through readback
        @(negedge clk);
        idle();
        fetch_valid = 1; end_l1 = 1;
        rd("R3 count decremented", 2'd3, 32'd3);

        // R6: inner loops back, outer untouched
        wr(2'd1, 32'd2);
        @(negedge clk);
        idle();
        fetch_valid = 1; end_l0 = 1; end_l1 = 1; seq_addr = 32'h600;
        #2;
        chk("R6 inner target", next_addr, 32'h200);
        rd("R6 outer held", 2'd3, 32'd3);
        rd("R6 inner decremented", 2'd1, 32'd1);

        report();
        $finish;
    end
endmodule